// File: doc/BRIEF.md
# IPv4/UDP Receive Filter and Decapsulator

This block sits behind an Ethernet receiver that has already accepted a frame. It takes the frame payload as a byte stream, starting at the first byte of the IPv4 header. It checks the IPv4 header and decides whether the packet is for this node. A packet that passes is stored and handed to the application with a small header of its own. The byte stream carries a first-byte marker, a last-byte marker and a frame-good flag that is valid together with the last byte.

A UDP datagram loses its UDP header and only the payload goes forward. A TCP segment goes forward whole, with its ports copied into the application header. Any other packet is dropped. The header sent to the application has 11 bytes, all multi-byte fields sent most significant byte first:
- a type byte (0x11 for UDP, 0x06 for TCP),
- a 16-bit payload length,
- the source port and the destination port,
- the sender's IPv4 address.

The packet data follows that header.

The block holds one packet at a time in a store of `DEPTH` bytes. While a packet is held, `pkt_avail` stays high and the input is stalled. The application reads the packet with valid/ready handshakes on the output. Both streams follow the usual rules:
- A byte moves on a clock edge where valid and ready are both high.
- The output holds its byte and its last marker steady while `out_ready` is low.
- `in_ready` falls while a packet is being committed or drained.

Top module: `ipv4_rx_filter`

## Requirements
- R1: After reset, `out_valid` and `pkt_avail` are low and `in_ready` is high.
- R2: An accepted UDP packet (protocol 17) is sent out as: byte 0x11, then the 16-bit payload length (IP total length minus 28), then the UDP source port, the UDP destination port and the 4-byte source IP address, then the UDP payload. The 8-byte UDP header is not sent out.
- R3: An accepted TCP packet (protocol 6) is sent out as: byte 0x06, then the length (IP total length minus 20), then the first four bytes of the segment as the source port and destination port, then the source IP, then the whole segment unchanged.
- R4: A packet is rejected unless the ones'-complement sum of the ten 16-bit header words is 0xFFFF. The sum includes the checksum field, and each word is taken high byte first from IP header bytes 0..19.
- R5: A packet is rejected unless its destination IP (header bytes 16..19) equals `local_ip` or equals 255.255.255.255.
- R6: A packet is rejected if header byte 0 is not 0x45 (version 4 with a 20-byte header). It is also rejected if its protocol byte (header byte 9) is neither 6 nor 17.
- R7: A packet is rejected in any of these cases:
  - `in_good` is low on its last byte.
  - The frame ends before the IP total length (header bytes 2..3) is reached.
  - The total length is below 28 for UDP or below 24 for TCP.

  Bytes after the total length (padding) are ignored.
- R8: A packet whose payload is longer than `DEPTH` bytes is rejected. A rejected packet produces no output and has no effect on the next packet.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged. `pkt_avail` is high from the commit until the last output byte has been taken.
- R10: `out_last` is high on exactly the final byte of each packet, which is byte 11 when the payload is empty. On the cycle after that byte is taken, `out_valid` and `pkt_avail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_ip | input | 32 | Configured IPv4 address of this node |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Marks the first byte of a frame payload |
| in_last | input | 1 | Marks the last byte of a frame payload |
| in_good | input | 1 | Frame passed link-level checks; valid with the last byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Application takes the output byte |
| out_data | output | 8 | Output byte (application header, then data) |
| out_last | output | 1 | Marks the last output byte of a packet |
| pkt_avail | output | 1 | A packet is waiting to be read |

## Verification
The bench builds the block with `DEPTH` = 64, instead of the default of 1500. With that value, a 64-byte UDP payload is the largest one accepted and a 65-byte payload is the smallest one rejected for size, so the size limit can be tested both ways with short frames. A scoreboard checks the output stream for each frame:
- with `out_ready` always high,
- with a repeating stall pattern on `out_ready`,
- after rejects, to show that a dropped frame does not corrupt the next one.

// File: rtl/ipv4_rx_pkg.sv
package ipv4_rx_pkg;
  localparam logic [7:0] VER_IHL_OK  = 8'h45;
  localparam logic [7:0] PROTO_UDP   = 8'h11;
  localparam logic [7:0] PROTO_TCP   = 8'h06;
  localparam int         IP_HDR_LEN  = 20;
  localparam int         UDP_HDR_LEN = 8;
  localparam int         APP_HDR_LEN = 11;
  localparam int         TCP_MIN_TOT = IP_HDR_LEN + 4;

  typedef struct packed {
    logic [7:0]  kind;
    logic [15:0] len;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [31:0] peer_ip;
  } app_hdr_t;
endpackage

// File: rtl/ipv4_rx_csum.sv
module ipv4_rx_csum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        odd,
  input  logic        restart,
  input  logic [7:0]  din,
  output logic [15:0] sum
);
  logic [7:0]  hi_q;
  logic [16:0] raw;
  logic [15:0] folded;

  assign raw    = {1'b0, sum} + {1'b0, hi_q, din};
  assign folded = raw[15:0] + {15'd0, raw[16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      sum  <= '0;
    end else if (en) begin
      if (!odd) begin
        hi_q <= din;
        if (restart) sum <= '0;
      end else begin
        sum <= folded;
      end
    end
  end
endmodule

// File: rtl/ipv4_rx_store.sv
module ipv4_rx_store #(
  parameter int DEPTH = 1500,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [CW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = (raddr < CW'(DEPTH)) ? mem[raddr] : 8'h00;

  // R8: the parser never writes beyond the store
  a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < CW'(DEPTH)));
endmodule

// File: rtl/ipv4_rx_emit.sv
module ipv4_rx_emit
  import ipv4_rx_pkg::*;
#(
  parameter int DEPTH = 1500,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  app_hdr_t      hdr,
  output logic [CW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  localparam int OW = CW + 4;

  app_hdr_t      hdr_q;
  logic [OW-1:0] oc;
  logic          busy;
  logic [3:0]    hsel;
  logic          in_hdr;

  assign in_hdr    = oc < OW'(APP_HDR_LEN);
  assign hsel      = 4'(APP_HDR_LEN - 1) - oc[3:0];
  assign rd_addr   = CW'(oc - OW'(APP_HDR_LEN));
  assign out_valid = busy;
  assign out_data  = in_hdr ? hdr_q[{hsel, 3'b000} +: 8] : rd_data;
  assign out_last  = busy && (oc == OW'(APP_HDR_LEN - 1) + OW'(hdr_q.len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      oc    <= '0;
      hdr_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      oc    <= '0;
      hdr_q <= hdr;
    end else if (busy && out_ready) begin
      if (out_last) busy <= 1'b0;
      oc <= oc + 1'b1;
    end
  end

  // R9: output stays stable while stalled
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R10: the stream goes idle right after its last byte is taken
  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
  // R9: a new packet is only committed to an idle emitter
  a_r9_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/ipv4_rx_filter.sv
module ipv4_rx_filter
  import ipv4_rx_pkg::*;
#(
  parameter int DEPTH = 1500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] local_ip,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_first,
  input  logic        in_last,
  input  logic        in_good,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        pkt_avail
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          fire;
  logic [15:0]   idx, pos;
  logic          bad;
  logic [15:0]   tot_len;
  logic [7:0]    proto;
  logic [31:0]   src_ip, dst_ip;
  logic [15:0]   sport, dport;
  logic [CW-1:0] wcnt;
  logic          commit_q;
  logic          busy;
  logic [15:0]   csum;
  logic          is_udp, proto_ok, data_byte, we;
  logic          complete, min_ok, len_ok, dst_ok, accept;
  logic [15:0]   pl_len;
  logic [CW-1:0] rd_addr;
  logic [7:0]    rd_data;
  app_hdr_t      hdr;

  assign fire     = in_valid && in_ready;
  assign pos      = in_first ? 16'd0 : idx;
  assign in_ready = !busy && !commit_q;
  assign pkt_avail = busy;
  assign busy     = out_valid;

  assign is_udp    = (proto == PROTO_UDP);
  assign proto_ok  = is_udp || (proto == PROTO_TCP);
  assign data_byte = (pos >= 16'(IP_HDR_LEN)) && (pos < tot_len) &&
                     (!is_udp || pos >= 16'(IP_HDR_LEN + UDP_HDR_LEN));
  assign we        = fire && data_byte && (wcnt < CW'(DEPTH));

  assign pl_len   = tot_len - (is_udp ? 16'(IP_HDR_LEN + UDP_HDR_LEN) : 16'(IP_HDR_LEN));
  assign min_ok   = tot_len >= (is_udp ? 16'(IP_HDR_LEN + UDP_HDR_LEN) : 16'(TCP_MIN_TOT));
  assign complete = ({1'b0, pos} + 17'd1) >= {1'b0, tot_len};
  assign len_ok   = pl_len <= 16'(DEPTH);
  assign dst_ok   = (dst_ip == local_ip) || (dst_ip == 32'hFFFF_FFFF);
  assign accept   = !bad && (pos != 16'd0) && in_good && proto_ok && min_ok &&
                    complete && len_ok && dst_ok && (csum == 16'hFFFF);

  assign hdr.kind    = is_udp ? PROTO_UDP : PROTO_TCP;
  assign hdr.len     = pl_len;
  assign hdr.sport   = sport;
  assign hdr.dport   = dport;
  assign hdr.peer_ip = src_ip;

  ipv4_rx_csum u_csum (
    .clk(clk), .rst_n(rst_n),
    .en(fire && pos < 16'(IP_HDR_LEN)), .odd(pos[0]), .restart(pos == 16'd0),
    .din(in_data), .sum(csum)
  );

  ipv4_rx_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(wcnt), .wdata(in_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  ipv4_rx_emit #(.DEPTH(DEPTH), .CW(CW)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(commit_q), .hdr(hdr),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      bad      <= 1'b0;
      tot_len  <= '0;
      proto    <= '0;
      src_ip   <= '0;
      dst_ip   <= '0;
      sport    <= '0;
      dport    <= '0;
      wcnt     <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= fire && in_last && accept;
      if (fire) begin
        idx <= (pos == 16'hFFFF) ? pos : pos + 16'd1;
        case (pos)
          16'd0:  bad            <= (in_data != VER_IHL_OK);
          16'd2:  tot_len[15:8]  <= in_data;
          16'd3:  tot_len[7:0]   <= in_data;
          16'd9:  proto          <= in_data;
          16'd20: sport[15:8]    <= in_data;
          16'd21: sport[7:0]     <= in_data;
          16'd22: dport[15:8]    <= in_data;
          16'd23: dport[7:0]     <= in_data;
          default: ;
        endcase
        if (pos >= 16'd12 && pos <= 16'd15) src_ip <= {src_ip[23:0], in_data};
        if (pos >= 16'd16 && pos <= 16'd19) dst_ip <= {dst_ip[23:0], in_data};
        if (in_last || pos == 16'd0) wcnt <= '0;
        else if (we)                 wcnt <= wcnt + 1'b1;
      end
    end
  end

  // R9: a packet becomes available only after a frame has ended
  a_r9_avail_after_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_avail) |-> $past(in_valid && in_last, 2));
endmodule

// File: tb/tb_ipv4_rx_filter.sv
module tb_ipv4_rx_filter;
  localparam int DEPTH = 64;
  localparam logic [31:0] MY_IP = 32'hC0A8_0332;
  localparam logic [31:0] PEER  = 32'h0A00_0107;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_good = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last, pkt_avail;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  ipv4_rx_filter #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .local_ip(MY_IP),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_good(in_good),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .pkt_avail(pkt_avail)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;
  int cyc = 0;
  string tag = "R1";
  logic [7:0] fr[$];
  logic [8:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic build(input logic [7:0] vihl, input logic [7:0] proto,
                       input logic [31:0] dst, input int n, input int seed,
                       input int tot_adj, input int pad, input logic [15:0] cks_xor,
                       input bit expect_ok);
    logic [7:0] seg[$];
    logic [7:0] h[20];
    logic [15:0] sp, dp, tot, cks;
    logic [16:0] s;
    seg = {};
    sp = 16'h1000 + 16'(seed);
    dp = 16'h2000 + 16'(seed);
    if (proto == 8'h11) begin
      seg.push_back(sp[15:8]); seg.push_back(sp[7:0]);
      seg.push_back(dp[15:8]); seg.push_back(dp[7:0]);
      seg.push_back(8'(((n + 8) >> 8))); seg.push_back(8'(n + 8));
      seg.push_back(8'h00); seg.push_back(8'h00);
    end
    for (int i = 0; i < n; i++) seg.push_back(8'(seed + i * 7 + 3));
    tot = 16'(20 + seg.size() + tot_adj);
    h = '{vihl, 8'h00, tot[15:8], tot[7:0], 8'h12, 8'h34, 8'h00, 8'h00, 8'h40, proto,
          8'h00, 8'h00, PEER[31:24], PEER[23:16], PEER[15:8], PEER[7:0],
          dst[31:24], dst[23:16], dst[15:8], dst[7:0]};
    s = '0;
    for (int w = 0; w < 10; w++) begin
      s = {1'b0, s[15:0]} + {1'b0, h[2*w], h[2*w+1]};
      s = {1'b0, s[15:0] + {15'd0, s[16]}};
    end
    cks = ~s[15:0] ^ cks_xor;
    h[10] = cks[15:8];
    h[11] = cks[7:0];
    fr = {};
    for (int i = 0; i < 20; i++) fr.push_back(h[i]);
    foreach (seg[i]) fr.push_back(seg[i]);
    for (int i = 0; i < pad; i++) fr.push_back(8'hEE);
    if (expect_ok) begin
      logic [7:0] e[$];
      e = {};
      e.push_back(proto);
      e.push_back(8'(n >> 8)); e.push_back(8'(n));
      if (proto == 8'h11) begin
        e.push_back(sp[15:8]); e.push_back(sp[7:0]);
        e.push_back(dp[15:8]); e.push_back(dp[7:0]);
      end else begin
        for (int i = 0; i < 4; i++) e.push_back(seg[i]);
      end
      e.push_back(PEER[31:24]); e.push_back(PEER[23:16]);
      e.push_back(PEER[15:8]);  e.push_back(PEER[7:0]);
      for (int i = 0; i < n; i++)
        e.push_back(seg[(proto == 8'h11) ? i + 8 : i]);
      foreach (e[i]) exp_q.push_back({(i == e.size() - 1), e[i]});
    end
  endtask

  task automatic send(input bit good);
    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fr[i];
      in_first = (i == 0);
      in_last  = (i == fr.size() - 1);
      in_good  = good;
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_good = 1'b0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!out_valid && !pkt_avail, req, "idle after packet", {out_valid, pkt_avail}, 0);
  endtask

  task automatic expect_drop(input string req);
    repeat (6) @(negedge clk);
    chk(!pkt_avail && !out_valid, req, "rejected packet produced output",
        {pkt_avail, out_valid}, 0);
  endtask

  // monitor / scoreboard
  initial begin
    logic prev_stall;
    logic [7:0] prev_data;
    logic prev_last;
    logic [8:0] e;
    prev_stall = 1'b0;
    prev_data = 8'h00;
    prev_last = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_mode ? (cyc % 3 != 2) : 1'b1;
      if (rst_n) begin
        if (prev_stall)
          chk(out_valid && out_data == prev_data && out_last == prev_last, "R9",
              "stalled output changed", {out_valid, out_last, out_data}, {1'b1, prev_last, prev_data});
        if (out_valid)
          chk(pkt_avail, "R9", "pkt_avail low during packet", pkt_avail, 1);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, tag, "unexpected output byte", out_data, 0);
          end else begin
            e = exp_q.pop_front();
            chk(out_data == e[7:0] && out_last == e[8], tag, "output byte/last",
                {out_last, out_data}, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        prev_last  = out_last;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    chk(!pkt_avail, "R1", "pkt_avail in reset", pkt_avail, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);

    tag = "R2";  build(8'h45, 8'h11, MY_IP, 5, 1, 0, 0, 0, 1); send(1); drain("R2");
    tag = "R5";  stall_mode = 1'b1;
    build(8'h45, 8'h11, 32'hFFFF_FFFF, 20, 2, 0, 0, 0, 1); send(1); drain("R5");
    stall_mode = 1'b0;
    tag = "R7";  build(8'h45, 8'h11, MY_IP, 2, 3, 0, 16, 0, 1); send(1); drain("R7");
    tag = "R3";  build(8'h45, 8'h06, MY_IP, 24, 4, 0, 0, 0, 1); send(1); drain("R3");

    tag = "R4";  build(8'h45, 8'h11, MY_IP, 6, 5, 0, 0, 16'h0001, 0); send(1); expect_drop("R4");
    tag = "R5";  build(8'h45, 8'h11, 32'hC0A8_0333, 6, 6, 0, 0, 0, 0); send(1); expect_drop("R5");
    tag = "R6";  build(8'h46, 8'h11, MY_IP, 6, 7, 0, 0, 0, 0); send(1); expect_drop("R6");
    build(8'h45, 8'h01, MY_IP, 8, 8, 0, 0, 0, 0); send(1); expect_drop("R6");
    tag = "R7";  build(8'h45, 8'h11, MY_IP, 6, 9, 0, 0, 0, 0); send(0); expect_drop("R7");
    build(8'h45, 8'h11, MY_IP, 6, 10, 4, 0, 0, 0); send(1); expect_drop("R7");

    tag = "R8";  stall_mode = 1'b1;
    build(8'h45, 8'h11, MY_IP, 64, 11, 0, 0, 0, 1); send(1); drain("R8");
    stall_mode = 1'b0;
    build(8'h45, 8'h11, MY_IP, 65, 12, 0, 0, 0, 0); send(1); expect_drop("R8");
    build(8'h45, 8'h11, MY_IP, 7, 13, 0, 0, 0, 1); send(1); drain("R8");

    tag = "R10"; build(8'h45, 8'h11, MY_IP, 0, 14, 0, 0, 0, 1); send(1); drain("R10");

    chk(exp_q.size() == 0, "R2", "bytes left unseen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule